// File: doc/BRIEF.md
# Switch Ingress Word Packer and Enqueue Controller

This block serves one ingress port of a shared-memory Ethernet switch. It accepts the 16-bit receive words delivered by a port's receive MAC. It gathers them into 64-bit quad-words for the write FIFO that feeds packet buffer memory. While the frame is still arriving, it pulls out the destination MAC address and asks the forwarding table for a lookup.

The block also decides when the packet is handed to the destination output queue. In store-and-forward mode the hand-off waits until the frame has ended, its FCS is good and no receive error was seen. In cut-through mode the hand-off happens as soon as enough bytes have been taken in to keep the output side from running dry. That amount is 290 bytes on a 100 Mb/s port and 98 bytes on a 10 Mb/s port. Once a frame has ended cleanly, its source MAC address is offered for address learning. A frame that ends badly produces a one-cycle discard strobe instead.

All requests (lookup, learn, enqueue) are level requests that stay up until the matching ready input is seen high at a clock edge. Word intake stops while the write FIFO reports full, and also while an end-of-frame request is still waiting.

Top module: `ingress_enqueue`

## Requirements
- R1: Accepted words fill a quad-word from the low lane upward: the first word of each quad-word goes to `qwData[15:0]`, the fourth to `qwData[63:48]`. A full quad-word is presented for one cycle with `qwBytes` = 8, one cycle after its fourth word is accepted.
- R2: The word accepted with `eof` flushes the quad-word being built. Unused upper lanes are zero, `qwBytes` = 2 × (words in it) and `qwLast` = 1.
- R3: One cycle after the third word of a frame is accepted, `lookupReq` rises. `lookupAddr` then equals {word0, word1, word2}, with word0 in bits 47:32.
- R4: With `cutThroughEn` = 0, `enqReq` rises only in the cycle after a good `eof` word is accepted. A good end means `fcsGood` = 1, no `rxErr` on any word of the frame, and at least 6 words.
- R5: A frame with `fcsGood` = 0 at `eof`, with `rxErr` on any of its words, or shorter than 6 words is never enqueued at its end and raises no `learnReq`. `discardPulse` is high for one cycle after its `eof` word is accepted.
- R6: With `cutThroughEn` = 1, `enqReq` rises in the cycle after the accepted byte count first reaches the threshold. The threshold is 290 bytes (word 145) when `fastPort` = 1 and 98 bytes (word 49) when `fastPort` = 0. This happens only if no `rxErr` has been seen in the frame so far.
- R7: In cut-through mode, a frame that ends before its threshold is enqueued only at a good end, as in R4.
- R8: After a good end, `learnReq` rises and `learnAddr` equals {word3, word4, word5}, with word3 in bits 47:32.
- R9: Each request stays high until its ready input is high at a clock edge, and falls in the next cycle.
- R10: `wordReady` is low while `qwFull` is high, and also while `enqReq` or `learnReq` is pending. It is low as well while `lookupReq` is pending between frames.
- R11: A cut-through frame that was already enqueued and then ends badly raises `discardPulse` and no `learnReq`.
- R12: After reset, all requests, `qwValid` and `discardPulse` are low, and `wordReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cutThroughEn | input | 1 | 1 selects cut-through enqueue, 0 store-and-forward |
| fastPort | input | 1 | 1 for a 100 Mb/s port, 0 for 10 Mb/s |
| wordValid | input | 1 | Receive word present |
| wordData | input | 16 | Receive word |
| sof | input | 1 | Word is the first of a frame |
| eof | input | 1 | Word is the last of a frame |
| rxErr | input | 1 | Receive error on this word |
| fcsGood | input | 1 | FCS check result, valid with eof |
| wordReady | output | 1 | Word is taken at the clock edge when valid and ready |
| qwFull | input | 1 | Write FIFO cannot take another quad-word |
| qwValid | output | 1 | Quad-word write strobe |
| qwData | output | 64 | Packed quad-word |
| qwBytes | output | 4 | Valid bytes in the quad-word |
| qwLast | output | 1 | Quad-word ends the frame |
| lookupReq | output | 1 | Forwarding lookup request |
| lookupAddr | output | 48 | Destination MAC address |
| lookupRdy | input | 1 | Lookup accepted |
| learnReq | output | 1 | Address learning request |
| learnAddr | output | 48 | Source MAC address |
| learnRdy | input | 1 | Learn accepted |
| enqReq | output | 1 | Output queue enqueue request |
| enqRdy | input | 1 | Enqueue accepted |
| discardPulse | output | 1 | Frame ended badly |

## Verification
The packer is exercised with a 10-word frame, which yields two full quad-words and a half-full tail, so lane order, zero padding and the byte count are each observed. Store-and-forward is tried with good frames, frames with a bad FCS, frames with a mid-frame receive error and runts. These separate the three ways a frame can be rejected. Cut-through is tried on fast and slow ports with long frames, a short frame, an early error and a late bad FCS. This shows the word at which enqueue fires, the fall-back for short frames, and the discard after an early hand-off. Separate runs hold `qwFull` and `enqRdy` low to show the intake stall and that requests are held.

// File: rtl/ingress_pkg.sv
`timescale 1ns/1ps
package ingress_pkg;
  // Control-to-datapath strobes for one accepted word.
  typedef struct packed {
    logic       take;      // word accepted this edge
    logic       first;     // word starts a frame
    logic       last;      // word ends a frame
    logic [2:0] addrSlot;  // header word index 0..5, or NO_SLOT
  } strobe_t;

  localparam logic [2:0] NO_SLOT = 3'd7;
endpackage

// File: rtl/ingress_datapath.sv
`timescale 1ns/1ps
module ingress_datapath
  import ingress_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  strobe_t                                stb,
  input  logic [WORD_W-1:0]                      wordData,
  input  logic                                   qwFull,
  output logic                                   qwValid,
  output logic [WORD_W*LANES-1:0]                qwData,
  output logic [$clog2(WORD_W*LANES/8+1)-1:0]    qwBytes,
  output logic                                   qwLast,
  output logic [47:0]                            dstAddr,
  output logic [47:0]                            srcAddr
);
  localparam int QW_W       = WORD_W * LANES;
  localparam int QW_BYTES   = QW_W / 8;
  localparam int BYTES_W    = $clog2(QW_BYTES + 1);
  localparam int LANE_W     = $clog2(LANES);
  localparam int ADDR_WORDS = 48 / WORD_W;

  logic [QW_W-1:0]   packReg;
  logic [LANE_W-1:0] packCnt;
  logic [LANE_W-1:0] slot;
  logic [QW_W-1:0]   nextPack;
  logic              flush;

  // Lanes below the slot keep earlier words, the slot takes the new word,
  // lanes above stay zero, which pads a short tail.
  always_comb begin
    slot     = stb.first ? '0 : packCnt;
    nextPack = '0;
    for (int l = 0; l < LANES; l++) begin
      if (l == int'(slot))
        nextPack[l*WORD_W +: WORD_W] = wordData;
      else if (l < int'(slot))
        nextPack[l*WORD_W +: WORD_W] = packReg[l*WORD_W +: WORD_W];
    end
    flush = stb.take && ((slot == LANE_W'(LANES-1)) || stb.last);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packReg <= '0;
      packCnt <= '0;
      qwValid <= 1'b0;
      qwData  <= '0;
      qwBytes <= '0;
      qwLast  <= 1'b0;
    end else begin
      qwValid <= flush;
      if (stb.take) begin
        packReg <= nextPack;
        packCnt <= flush ? '0 : slot + 1'b1;
      end
      if (flush) begin
        qwData  <= nextPack;
        qwBytes <= BYTES_W'((int'(slot) + 1) * (WORD_W / 8));
        qwLast  <= stb.last;
      end
    end
  end

  // Header capture: first words form the destination, next ones the source.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstAddr <= '0;
      srcAddr <= '0;
    end else if (stb.take && stb.addrSlot != NO_SLOT) begin
      if (int'(stb.addrSlot) < ADDR_WORDS)
        dstAddr[(ADDR_WORDS-1-int'(stb.addrSlot))*WORD_W +: WORD_W] <= wordData;
      else if (int'(stb.addrSlot) < 2*ADDR_WORDS)
        srcAddr[(2*ADDR_WORDS-1-int'(stb.addrSlot))*WORD_W +: WORD_W] <= wordData;
    end
  end

  // R1: a quad-word that does not end the frame is always complete
  a_r1_full_quad: assert property (@(posedge clk) disable iff (!rstN)
    qwValid && !qwLast |-> qwBytes == BYTES_W'(QW_BYTES));

  // R2: a tail quad-word carries a non-zero, bounded byte count
  a_r2_tail_bytes: assert property (@(posedge clk) disable iff (!rstN)
    qwValid |-> (qwBytes != '0) && (qwBytes <= BYTES_W'(QW_BYTES)));

  // R10: the control never hands over a word while the FIFO is full
  a_r10_no_take_full: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> !qwFull);
endmodule

// File: rtl/ingress_control.sv
`timescale 1ns/1ps
module ingress_control
  import ingress_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int CNT_W         = 12,
  parameter int FAST_CT_BYTES = 290,
  parameter int SLOW_CT_BYTES = 98
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cutThroughEn,
  input  logic    fastPort,
  input  logic    wordValid,
  input  logic    sof,
  input  logic    eof,
  input  logic    rxErr,
  input  logic    fcsGood,
  input  logic    qwFull,
  input  logic    lookupRdy,
  input  logic    learnRdy,
  input  logic    enqRdy,
  output logic    wordReady,
  output strobe_t stb,
  output logic    lookupReq,
  output logic    learnReq,
  output logic    enqReq,
  output logic    discardPulse
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int ADDR_WORDS = 48 / WORD_W;
  localparam int MIN_WORDS  = 2 * ADDR_WORDS;
  localparam int FAST_WORDS = (FAST_CT_BYTES + WORD_BYTES - 1) / WORD_BYTES;
  localparam int SLOW_WORDS = (SLOW_CT_BYTES + WORD_BYTES - 1) / WORD_BYTES;

  logic             inFrame;
  logic             errSeen;
  logic             enqDone;
  logic [CNT_W-1:0] wordIdx;

  logic             take;
  logic [CNT_W-1:0] curIdx;
  logic [CNT_W-1:0] newIdx;
  logic [CNT_W-1:0] ctWords;
  logic             errNow;
  logic             enqPrior;
  logic             ctHit;
  logic             frameGood;

  always_comb begin
    wordReady = !qwFull && !enqReq && !learnReq && !(lookupReq && !inFrame);
    take      = wordValid && wordReady;
    curIdx    = sof ? '0 : wordIdx;
    newIdx    = (curIdx == '1) ? curIdx : curIdx + 1'b1;
    errNow    = (!sof && errSeen) || rxErr;
    enqPrior  = !sof && enqDone;
    ctWords   = fastPort ? CNT_W'(FAST_WORDS) : CNT_W'(SLOW_WORDS);
    ctHit     = cutThroughEn && !enqPrior && !errNow && !eof && (newIdx >= ctWords);
    frameGood = fcsGood && !errNow && (newIdx >= CNT_W'(MIN_WORDS));

    stb.take     = take;
    stb.first    = sof;
    stb.last     = eof;
    stb.addrSlot = (curIdx < CNT_W'(MIN_WORDS)) ? curIdx[2:0] : NO_SLOT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      errSeen      <= 1'b0;
      enqDone      <= 1'b0;
      wordIdx      <= '0;
      lookupReq    <= 1'b0;
      learnReq     <= 1'b0;
      enqReq       <= 1'b0;
      discardPulse <= 1'b0;
    end else begin
      discardPulse <= 1'b0;
      if (lookupReq && lookupRdy) lookupReq <= 1'b0;
      if (learnReq && learnRdy)   learnReq  <= 1'b0;
      if (enqReq && enqRdy)       enqReq    <= 1'b0;
      if (take) begin
        wordIdx <= newIdx;
        errSeen <= errNow;
        inFrame <= !eof;
        enqDone <= enqPrior || ctHit;
        if (curIdx == CNT_W'(ADDR_WORDS - 1)) lookupReq <= 1'b1;
        if (ctHit) enqReq <= 1'b1;
        if (eof) begin
          if (frameGood) begin
            learnReq <= 1'b1;
            if (!enqPrior) enqReq <= 1'b1;
          end else begin
            discardPulse <= 1'b1;
          end
        end
      end
    end
  end

  // R9: requests hold until accepted, then fall
  a_r9_lookup_hold: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq && !lookupRdy |=> lookupReq);
  a_r9_learn_hold: assert property (@(posedge clk) disable iff (!rstN)
    learnReq && !learnRdy |=> learnReq);
  a_r9_enq_hold: assert property (@(posedge clk) disable iff (!rstN)
    enqReq && !enqRdy |=> enqReq);
  a_r9_enq_drop: assert property (@(posedge clk) disable iff (!rstN)
    enqReq && enqRdy |=> !enqReq);

  // R5/R8: a discarded frame never starts a learn request
  a_r8_no_learn_discard: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |-> !$rose(learnReq));
endmodule

// File: rtl/ingress_enqueue.sv
`timescale 1ns/1ps
module ingress_enqueue
  import ingress_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int LANES         = 4,
  parameter int CNT_W         = 12,
  parameter int FAST_CT_BYTES = 290,
  parameter int SLOW_CT_BYTES = 98
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cutThroughEn,
  input  logic                                fastPort,
  input  logic                                wordValid,
  input  logic [WORD_W-1:0]                   wordData,
  input  logic                                sof,
  input  logic                                eof,
  input  logic                                rxErr,
  input  logic                                fcsGood,
  output logic                                wordReady,
  input  logic                                qwFull,
  output logic                                qwValid,
  output logic [WORD_W*LANES-1:0]             qwData,
  output logic [$clog2(WORD_W*LANES/8+1)-1:0] qwBytes,
  output logic                                qwLast,
  output logic                                lookupReq,
  output logic [47:0]                         lookupAddr,
  input  logic                                lookupRdy,
  output logic                                learnReq,
  output logic [47:0]                         learnAddr,
  input  logic                                learnRdy,
  output logic                                enqReq,
  input  logic                                enqRdy,
  output logic                                discardPulse
);
  strobe_t stb;

  ingress_control #(
    .WORD_W(WORD_W), .CNT_W(CNT_W),
    .FAST_CT_BYTES(FAST_CT_BYTES), .SLOW_CT_BYTES(SLOW_CT_BYTES)
  ) u_control (
    .clk(clk), .rstN(rstN), .cutThroughEn(cutThroughEn), .fastPort(fastPort),
    .wordValid(wordValid), .sof(sof), .eof(eof), .rxErr(rxErr), .fcsGood(fcsGood),
    .qwFull(qwFull), .lookupRdy(lookupRdy), .learnRdy(learnRdy), .enqRdy(enqRdy),
    .wordReady(wordReady), .stb(stb), .lookupReq(lookupReq), .learnReq(learnReq),
    .enqReq(enqReq), .discardPulse(discardPulse)
  );

  ingress_datapath #(.WORD_W(WORD_W), .LANES(LANES)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .wordData(wordData), .qwFull(qwFull),
    .qwValid(qwValid), .qwData(qwData), .qwBytes(qwBytes), .qwLast(qwLast),
    .dstAddr(lookupAddr), .srcAddr(learnAddr)
  );
endmodule

// File: tb/ingress_enqueue_bench.sv
`timescale 1ns/1ps
module ingress_enqueue_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, cutThroughEn, fastPort, wordValid, sof, eof, rxErr, fcsGood;
  logic [15:0] wordData;
  logic        wordReady, qwFull, qwValid, qwLast;
  logic [63:0] qwData;
  logic [3:0]  qwBytes;
  logic        lookupReq, lookupRdy, learnReq, learnRdy, enqReq, enqRdy, discardPulse;
  logic [47:0] lookupAddr, learnAddr;

  ingress_enqueue u_ingress_enqueue (
    .clk(clk), .rstN(rstN), .cutThroughEn(cutThroughEn), .fastPort(fastPort),
    .wordValid(wordValid), .wordData(wordData), .sof(sof), .eof(eof),
    .rxErr(rxErr), .fcsGood(fcsGood), .wordReady(wordReady), .qwFull(qwFull),
    .qwValid(qwValid), .qwData(qwData), .qwBytes(qwBytes), .qwLast(qwLast),
    .lookupReq(lookupReq), .lookupAddr(lookupAddr), .lookupRdy(lookupRdy),
    .learnReq(learnReq), .learnAddr(learnAddr), .learnRdy(learnRdy),
    .enqReq(enqReq), .enqRdy(enqRdy), .discardPulse(discardPulse)
  );

  int checks = 0;
  int fails  = 0;

  // Observed events, sampled at falling edges
  int          acceptCnt, qwN, lookupCnt, learnCnt, enqCnt, discardCnt, enqAtWord;
  logic [47:0] seenLookup, seenLearn;
  logic [63:0] qwD [0:15];
  logic [3:0]  qwB [0:15];
  logic        qwL [0:15];

  always @(negedge clk) begin
    if (rstN) begin
      if (enqReq && enqRdy) begin enqCnt++; enqAtWord = acceptCnt; end
      if (lookupReq && lookupRdy) begin lookupCnt++; seenLookup = lookupAddr; end
      if (learnReq && learnRdy) begin learnCnt++; seenLearn = learnAddr; end
      if (discardPulse) discardCnt++;
      if (qwValid && qwN < 16) begin
        qwD[qwN] = qwData; qwB[qwN] = qwBytes; qwL[qwN] = qwLast; qwN++;
      end
      if (wordValid && wordReady) acceptCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    acceptCnt = 0; qwN = 0; lookupCnt = 0; learnCnt = 0; enqCnt = 0;
    discardCnt = 0; enqAtWord = -1; seenLookup = '0; seenLearn = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(input int n, input logic [15:0] base, input int errAt,
                           input logic fcs);
    for (int i = 0; i < n; i++) begin
      wordValid = 1'b1;
      wordData  = base + 16'(i);
      sof       = (i == 0);
      eof       = (i == n - 1);
      rxErr     = (i == errAt);
      fcsGood   = (i == n - 1) ? fcs : 1'b0;
      do @(negedge clk); while (!wordReady);
      @(posedge clk);
      #1;
    end
    wordValid = 1'b0; sof = 1'b0; eof = 1'b0; rxErr = 1'b0; fcsGood = 1'b0;
  endtask

  task automatic testReset();
    check(wordReady == 1'b1, "R12 wordReady after reset", 64'(wordReady), 64'd1);
    check({lookupReq, learnReq, enqReq} == 3'b000, "R12 requests after reset",
          64'({lookupReq, learnReq, enqReq}), 64'd0);
    check({qwValid, discardPulse} == 2'b00, "R12 strobes after reset",
          64'({qwValid, discardPulse}), 64'd0);
  endtask

  task automatic testStoreGood();
    logic [15:0] b;
    b = 16'h1000;
    clearStats(); cutThroughEn = 1'b0;
    sendFrame(10, b, -1, 1'b1);
    idle(4);
    check(qwN == 3, "R1 quad-word count", 64'(qwN), 64'd3);
    check(qwD[0] == {b+16'd3, b+16'd2, b+16'd1, b}, "R1 lane order", qwD[0],
          {b+16'd3, b+16'd2, b+16'd1, b});
    check(qwB[0] == 4'd8 && qwL[0] == 1'b0, "R1 full byte count", 64'({qwL[0], qwB[0]}), 64'h8);
    check(qwD[2] == {32'h0, b+16'd9, b+16'd8}, "R2 tail padding", qwD[2],
          {32'h0, b+16'd9, b+16'd8});
    check(qwB[2] == 4'd4 && qwL[2], "R2 tail bytes/last", 64'({qwL[2], qwB[2]}), 64'h14);
    check(lookupCnt == 1 && seenLookup == {b, b+16'd1, b+16'd2}, "R3 lookup address",
          64'(seenLookup), 64'({b, b+16'd1, b+16'd2}));
    check(enqCnt == 1 && enqAtWord == 10, "R4 enqueue after eof", 64'(enqAtWord), 64'd10);
    check(learnCnt == 1 && seenLearn == {b+16'd3, b+16'd4, b+16'd5}, "R8 learn address",
          64'(seenLearn), 64'({b+16'd3, b+16'd4, b+16'd5}));
    check(discardCnt == 0, "R4 no discard", 64'(discardCnt), 64'd0);
  endtask

  task automatic testStoreBad(input int n, input int errAt, input logic fcs, input string tag);
    clearStats(); cutThroughEn = 1'b0;
    sendFrame(n, 16'h2000, errAt, fcs);
    idle(4);
    check(enqCnt == 0, {"R5 no enqueue ", tag}, 64'(enqCnt), 64'd0);
    check(learnCnt == 0, {"R5 no learn ", tag}, 64'(learnCnt), 64'd0);
    check(discardCnt == 1, {"R5 discard ", tag}, 64'(discardCnt), 64'd1);
  endtask

  task automatic testCut(input logic fast, input int n, input int errAt, input logic fcs,
                         input int expEnq, input int expAt, input int expLearn,
                         input int expDisc, input string tag);
    clearStats(); cutThroughEn = 1'b1; fastPort = fast;
    sendFrame(n, 16'h3000, errAt, fcs);
    idle(4);
    check(enqCnt == expEnq, {tag, " enqueue count"}, 64'(enqCnt), 64'(expEnq));
    if (expEnq != 0)
      check(enqAtWord == expAt, {tag, " enqueue word"}, 64'(enqAtWord), 64'(expAt));
    check(learnCnt == expLearn, {tag, " learn count"}, 64'(learnCnt), 64'(expLearn));
    check(discardCnt == expDisc, {tag, " discard count"}, 64'(discardCnt), 64'(expDisc));
    cutThroughEn = 1'b0;
  endtask

  task automatic testStall();
    clearStats(); cutThroughEn = 1'b0; qwFull = 1'b1;
    fork
      sendFrame(8, 16'h4000, -1, 1'b1);
      begin
        idle(5);
        check(wordReady == 1'b0, "R10 ready low when full", 64'(wordReady), 64'd0);
        check(acceptCnt == 0 && qwN == 0, "R10 nothing taken when full", 64'(acceptCnt), 64'd0);
        qwFull = 1'b0;
      end
    join
    idle(4);
    check(qwN == 2 && enqCnt == 1, "R10 frame completes after release", 64'(qwN), 64'd2);
  endtask

  task automatic testHold();
    clearStats(); cutThroughEn = 1'b0; enqRdy = 1'b0;
    sendFrame(8, 16'h5000, -1, 1'b1);
    idle(5);
    check(enqReq == 1'b1 && enqCnt == 0, "R9 enqueue held", 64'(enqReq), 64'd1);
    check(wordReady == 1'b0, "R10 ready low while enqueue pending", 64'(wordReady), 64'd0);
    enqRdy = 1'b1;
    idle(3);
    check(enqCnt == 1 && enqReq == 1'b0, "R9 enqueue drops after ready", 64'(enqReq), 64'd0);
  endtask

  initial begin
    rstN = 1'b0; cutThroughEn = 1'b0; fastPort = 1'b1; wordValid = 1'b0;
    wordData = '0; sof = 1'b0; eof = 1'b0; rxErr = 1'b0; fcsGood = 1'b0;
    qwFull = 1'b0; lookupRdy = 1'b1; learnRdy = 1'b1; enqRdy = 1'b1;
    clearStats();
    idle(4);
    rstN = 1'b1;
    idle(1);
    testReset();
    testStoreGood();
    testStoreBad(10, -1, 1'b0, "bad fcs");
    testStoreBad(10, 5, 1'b1, "rx error");
    testStoreBad(4, -1, 1'b1, "runt");
    testCut(1'b1, 200, -1, 1'b1, 1, 145, 1, 0, "R6 fast");
    testCut(1'b0, 60, -1, 1'b1, 1, 49, 1, 0, "R6 slow");
    testCut(1'b0, 20, -1, 1'b1, 1, 20, 1, 0, "R7 short");
    testCut(1'b0, 80, 10, 1'b1, 0, 0, 0, 1, "R6 early error");
    testCut(1'b0, 80, -1, 1'b0, 1, 49, 0, 1, "R11 late bad fcs");
    testStall();
    testHold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog R1..R12 run actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule